// File: doc/BRIEF.md
# Receive Packet Status Queue

This block records one status entry for each packet that the receive MAC places in the receive data FIFO. It always shows the host the status of the oldest packet. It counts the bytes the host has taken from that packet, and it lets the host drop the oldest packet whether or not all of its bytes have been read. The packet memory itself is outside this block. Each entry keeps only the number of bytes that arrived for its packet.

The MAC side gives four things: a start pulse, one byte pulse per byte written, an end pulse with a 4-bit error code, and a level that says the data FIFO is full. The host side gives a byte-read strobe, a discard-oldest command and a receive-reset command. The outputs are:

- a 16-bit status word;
- four level flags: receiving, status-queue-full overrun, FIFO overrun and read underrun;
- two single-cycle events: adapter failure and receive complete.

Top module: `rx_status_queue`

## Requirements
- R1: With no packet queued, the status word reads 0x8000: bit 15 set and all other bits zero.
- R2: When the oldest packet has been closed, bit 15 of the status word is 0 and bits 10..0 hold the number of bytes it received.
- R3: A packet that receives more than MAXLEN bytes keeps a count of MAXLEN. When it closes, its error field (bits 14..11) reads 4'b1001, whatever code came with the end pulse.
- R4: The status-overrun flag is 1 exactly when DEPTH packets are queued. While it is set, a start pulse is refused and the receiving flag stays 0. It clears without host action once one packet is discarded.
- R5: The FIFO-overrun flag is set in the cycle after fifoFull is high. While it is set, start pulses are refused. It stays set after fifoFull falls and clears on the next host byte read that succeeds while fifoFull is low.
- R6: A host read with no unread received byte left in the oldest packet sets the underrun flag and pulses adapterFail for one cycle. The underrun flag stays set through discards. Only the receive-reset command or the block reset clears it.
- R7: The receiving flag is 1 from an accepted start until the end pulse. While the oldest packet is still being received, the status word has bit 15 set, bits 14..11 zero, and bits 10..0 equal to the bytes received so far.
- R8: Discard removes the oldest closed packet, along with any unread bytes, and shows the next packet's status, or 0x8000 if none remains. A discard is ignored when the oldest packet is still open or the queue is empty.
- R9: rxComplete pulses for one cycle in two cases: when a packet closes while it is the only queued packet, and after a discard that leaves a closed packet at the head. It does not pulse when a packet closes behind an older one.
- R10: Only these end codes are kept in bits 14..11: 1000 (overrun), 1011 (runt), 1100 (alignment), 1101 (CRC), 1001 (oversize) and 0010 (dribble). Any other code is stored as 0000. Bit 14 is therefore the error flag.
- R11: The receive-reset command empties the queue, so the status reads 0x8000, the receiving flag is 0 and the status-overrun flag is 0. It also clears the underrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxStart | input | 1 | MAC starts a packet |
| rxByte | input | 1 | MAC wrote one byte of the current packet |
| rxEnd | input | 1 | MAC ends the current packet |
| rxCode | input | 4 | Error code that comes with rxEnd |
| fifoFull | input | 1 | Receive data FIFO is full |
| hostRead | input | 1 | Host reads one byte of the oldest packet |
| discardTop | input | 1 | Host drops the oldest packet |
| rxReset | input | 1 | Receive-reset command |
| statusWord | output | 16 | Status of the oldest packet |
| receiving | output | 1 | A packet is being written |
| statusOverrun | output | 1 | Status queue is full |
| rxOverrun | output | 1 | Data FIFO overrun is pending |
| rxUnderrun | output | 1 | Host read past the received data |
| adapterFail | output | 1 | One-cycle failure event |
| rxComplete | output | 1 | One-cycle receive-complete event |

## Verification
The bench builds the block with DEPTH = 4 and MAXLEN = 20. With these values, filling the queue takes four short packets, and overrunning the length limit takes 25 byte pulses instead of more than 1500. This puts the full-queue refusal, the automatic recovery after a discard and the oversize saturation within a few hundred cycles. The queue holds three or four entries at once, so head-pointer wrap-around and the receive-complete re-raise after a discard are also exercised.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic alloc;
    logic bump;
    logic close;
    logic flush;
  } rxqStrobe_t;

  localparam logic [3:0] CODE_OVERSIZE = 4'b1001;

  function automatic logic [3:0] normCode(input logic [3:0] c);
    case (c)
      4'b1000, 4'b1011, 4'b1100, 4'b1101, 4'b1001, 4'b0010: normCode = c;
      default: normCode = 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int MAXLEN = 1514,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(MAXLEN + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  rxqStrobe_t    strb,
  input  logic [IW-1:0] allocIdx,
  input  logic [IW-1:0] curIdx,
  input  logic [IW-1:0] headIdx,
  input  logic [IW-1:0] nextIdx,
  input  logic          queueEmpty,
  input  logic [3:0]    endCode,
  output logic [CW-1:0] headCnt,
  output logic          headDone,
  output logic          nextDone,
  output logic [15:0]   statusWord
);

  logic [CW-1:0] cnt  [DEPTH];
  logic [3:0]    code [DEPTH];
  logic [DEPTH-1:0] done;
  logic [DEPTH-1:0] ovf;
  logic atLimit;

  assign atLimit = (cnt[curIdx] == CW'(MAXLEN));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done <= '0;
      ovf  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        cnt[i]  <= '0;
        code[i] <= '0;
      end
    end else if (strb.flush) begin
      done <= '0;
      ovf  <= '0;
    end else begin
      if (strb.alloc) begin
        cnt[allocIdx]  <= '0;
        code[allocIdx] <= '0;
        done[allocIdx] <= 1'b0;
        ovf[allocIdx]  <= 1'b0;
      end
      if (strb.bump) begin
        if (atLimit) ovf[curIdx] <= 1'b1;
        else         cnt[curIdx] <= cnt[curIdx] + 1'b1;
      end
      if (strb.close) begin
        done[curIdx] <= 1'b1;
        code[curIdx] <= (ovf[curIdx] || (strb.bump && atLimit)) ?
                        CODE_OVERSIZE : normCode(endCode);
      end
    end
  end

  logic [10:0] cntExt;
  assign cntExt   = 11'(cnt[headIdx]);
  assign headCnt  = cnt[headIdx];
  assign headDone = done[headIdx];
  assign nextDone = done[nextIdx];

  always_comb begin
    if (queueEmpty)    statusWord = 16'h8000;
    else if (headDone) statusWord = {1'b0, code[headIdx], cntExt};
    else               statusWord = {1'b1, 4'b0000, cntExt};
  end

endmodule

// File: rtl/rxq_control.sv
module rxq_control
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int MAXLEN = 1514,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(MAXLEN + 1),
  localparam int UW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxStart,
  input  logic          rxByte,
  input  logic          rxEnd,
  input  logic          fifoFull,
  input  logic          hostRead,
  input  logic          discardTop,
  input  logic          rxReset,
  input  logic [CW-1:0] headCnt,
  input  logic          headDone,
  input  logic          nextDone,
  output rxqStrobe_t    strb,
  output logic [IW-1:0] allocIdx,
  output logic [IW-1:0] curIdx,
  output logic [IW-1:0] headIdx,
  output logic [IW-1:0] nextIdx,
  output logic          queueEmpty,
  output logic          receiving,
  output logic          statusOverrun,
  output logic          rxOverrun,
  output logic          rxUnderrun,
  output logic          adapterFail,
  output logic          rxComplete
);

  function automatic logic [IW-1:0] wrapInc(input logic [IW-1:0] p);
    wrapInc = (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [IW-1:0] head, tail, cur;
  logic [UW-1:0] used;
  logic [CW-1:0] readCnt;
  logic accept, pop, readOk, readBad, closeNow, full;

  assign full       = (used == UW'(DEPTH));
  assign queueEmpty = (used == '0);
  assign closeNow   = rxEnd && receiving;
  assign accept     = rxStart && !receiving && !full && !rxOverrun && !fifoFull;
  assign pop        = discardTop && !queueEmpty && headDone;
  assign readOk     = hostRead && !queueEmpty && (readCnt < headCnt);
  assign readBad    = hostRead && !readOk;

  assign headIdx  = head;
  assign nextIdx  = wrapInc(head);
  assign allocIdx = tail;
  assign curIdx   = cur;
  assign statusOverrun = full;

  always_comb begin
    strb.flush = rxReset;
    strb.alloc = accept && !rxReset;
    strb.bump  = rxByte && receiving && !rxReset;
    strb.close = closeNow && !rxReset;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      head <= '0; tail <= '0; cur <= '0; used <= '0;
      readCnt <= '0; receiving <= 1'b0;
      rxOverrun <= 1'b0; rxUnderrun <= 1'b0;
      adapterFail <= 1'b0; rxComplete <= 1'b0;
    end else if (rxReset) begin
      head <= '0; tail <= '0; cur <= '0; used <= '0;
      readCnt <= '0; receiving <= 1'b0;
      rxUnderrun <= 1'b0;
      adapterFail <= 1'b0; rxComplete <= 1'b0;
      if (fifoFull) rxOverrun <= 1'b1;
    end else begin
      if (accept) begin
        cur       <= tail;
        tail      <= wrapInc(tail);
        receiving <= 1'b1;
      end else if (closeNow) begin
        receiving <= 1'b0;
      end
      used <= used + UW'(accept) - UW'(pop);
      if (pop) begin
        head    <= wrapInc(head);
        readCnt <= '0;
      end else if (readOk) begin
        readCnt <= readCnt + 1'b1;
      end
      if (fifoFull)    rxOverrun <= 1'b1;
      else if (readOk) rxOverrun <= 1'b0;
      if (readBad) rxUnderrun <= 1'b1;
      adapterFail <= readBad;
      rxComplete  <= (closeNow && (cur == head) && !pop) ||
                     (pop && (used >= UW'(2)) &&
                      (nextDone || (closeNow && (cur == nextIdx))));
    end
  end

endmodule

// File: rtl/rx_status_queue.sv
module rx_status_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int MAXLEN = 1514
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxStart,
  input  logic        rxByte,
  input  logic        rxEnd,
  input  logic [3:0]  rxCode,
  input  logic        fifoFull,
  input  logic        hostRead,
  input  logic        discardTop,
  input  logic        rxReset,
  output logic [15:0] statusWord,
  output logic        receiving,
  output logic        statusOverrun,
  output logic        rxOverrun,
  output logic        rxUnderrun,
  output logic        adapterFail,
  output logic        rxComplete
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(MAXLEN + 1);

  rxqStrobe_t    strb;
  logic [IW-1:0] allocIdx, curIdx, headIdx, nextIdx;
  logic [CW-1:0] headCnt;
  logic          headDone, nextDone, queueEmpty;

  rxq_control #(.DEPTH(DEPTH), .MAXLEN(MAXLEN)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .rxStart(rxStart), .rxByte(rxByte), .rxEnd(rxEnd),
    .fifoFull(fifoFull), .hostRead(hostRead),
    .discardTop(discardTop), .rxReset(rxReset),
    .headCnt(headCnt), .headDone(headDone), .nextDone(nextDone),
    .strb(strb), .allocIdx(allocIdx), .curIdx(curIdx),
    .headIdx(headIdx), .nextIdx(nextIdx), .queueEmpty(queueEmpty),
    .receiving(receiving), .statusOverrun(statusOverrun),
    .rxOverrun(rxOverrun), .rxUnderrun(rxUnderrun),
    .adapterFail(adapterFail), .rxComplete(rxComplete)
  );

  rxq_datapath #(.DEPTH(DEPTH), .MAXLEN(MAXLEN)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .allocIdx(allocIdx), .curIdx(curIdx),
    .headIdx(headIdx), .nextIdx(nextIdx),
    .queueEmpty(queueEmpty), .endCode(rxCode),
    .headCnt(headCnt), .headDone(headDone), .nextDone(nextDone),
    .statusWord(statusWord)
  );

endmodule

// File: rtl/rx_status_queue_chk.sv
module rx_status_queue_chk #(
  parameter int MAXLEN = 1514
) (
  input logic        clk,
  input logic        rstN,
  input logic        rxStart,
  input logic        fifoFull,
  input logic        rxReset,
  input logic [15:0] statusWord,
  input logic        receiving,
  input logic        statusOverrun,
  input logic        rxOverrun,
  input logic        rxUnderrun,
  input logic        adapterFail
);

  a_r1_empty_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!receiving && statusWord[15]) |-> (statusWord[14:0] == 15'd0));

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[10:0] <= 11'(MAXLEN)));

  a_r4_full_refuses: assert property (@(posedge clk) disable iff (!rstN)
    (statusOverrun && !receiving && rxStart) |=> !receiving);

  a_r5_full_sets: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |=> rxOverrun);

  a_r6_underrun_holds: assert property (@(posedge clk) disable iff (!rstN)
    (rxUnderrun && !rxReset) |=> rxUnderrun);

  a_r6_fail_implies_underrun: assert property (@(posedge clk) disable iff (!rstN)
    adapterFail |-> rxUnderrun);

  a_r10_class_legal: assert property (@(posedge clk) disable iff (!rstN)
    !statusWord[15] |-> (statusWord[14:11] inside
      {4'b0000, 4'b1000, 4'b1011, 4'b1100, 4'b1101, 4'b1001, 4'b0010}));

endmodule

bind rx_status_queue rx_status_queue_chk #(.MAXLEN(MAXLEN)) u_chk (
  .clk(clk), .rstN(rstN), .rxStart(rxStart), .fifoFull(fifoFull),
  .rxReset(rxReset), .statusWord(statusWord), .receiving(receiving),
  .statusOverrun(statusOverrun), .rxOverrun(rxOverrun),
  .rxUnderrun(rxUnderrun), .adapterFail(adapterFail)
);

// File: tb/test_rx_status_queue.sv
`timescale 1ns/1ps
module test_rx_status_queue;

  localparam int DEPTH  = 4;
  localparam int MAXLEN = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxStart = 0, rxByte = 0, rxEnd = 0, fifoFull = 0;
  logic hostRead = 0, discardTop = 0, rxReset = 0;
  logic [3:0] rxCode = '0;
  logic [15:0] statusWord;
  logic receiving, statusOverrun, rxOverrun, rxUnderrun, adapterFail, rxComplete;

  int nRun = 0;
  int nFail = 0;
  logic [15:0] expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  rx_status_queue #(.DEPTH(DEPTH), .MAXLEN(MAXLEN)) i_rx_status_queue (
    .clk(clk), .rstN(rstN), .rxStart(rxStart), .rxByte(rxByte),
    .rxEnd(rxEnd), .rxCode(rxCode), .fifoFull(fifoFull),
    .hostRead(hostRead), .discardTop(discardTop), .rxReset(rxReset),
    .statusWord(statusWord), .receiving(receiving),
    .statusOverrun(statusOverrun), .rxOverrun(rxOverrun),
    .rxUnderrun(rxUnderrun), .adapterFail(adapterFail),
    .rxComplete(rxComplete)
  );

  // scoreboard monitor: compares queued expectations with the status word
  always begin
    @(negedge clk);
    #1;
    while (expQ.size() > 0) begin
      logic [15:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      nRun++;
      if (statusWord !== e) begin
        nFail++;
        $display("FAIL %s statusWord actual=%h expected=%h", t, statusWord, e);
      end
    end
  end

  task automatic sbExp(input logic [15:0] e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
  endtask

  task automatic chk(input string t, input logic got, input logic exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s actual=%b expected=%b", t, got, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic b, input logic e,
                     input logic [3:0] c, input logic rd,
                     input logic ds, input logic rr);
    @(negedge clk);
    rxStart = s; rxByte = b; rxEnd = e; rxCode = c;
    hostRead = rd; discardTop = ds; rxReset = rr;
    @(negedge clk);
    rxStart = 0; rxByte = 0; rxEnd = 0; rxCode = '0;
    hostRead = 0; discardTop = 0; rxReset = 0;
  endtask

  task automatic startPkt(); cyc(1,0,0,4'h0,0,0,0); endtask
  task automatic bytes(input int n);
    for (int i = 0; i < n; i++) cyc(0,1,0,4'h0,0,0,0);
  endtask
  task automatic endPkt(input logic [3:0] c); cyc(0,0,1,c,0,0,0); endtask
  task automatic readB(); cyc(0,0,0,4'h0,1,0,0); endtask
  task automatic discard(); cyc(0,0,0,4'h0,0,1,0); endtask
  task automatic rxRst(); cyc(0,0,0,4'h0,0,0,1); endtask
  task automatic idle(); cyc(0,0,0,4'h0,0,0,0); endtask

  initial begin
    #100000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    sbExp(16'h8000, "R1 reset empty");
    chk("R1 reset receiving", receiving, 0);
    chk("R1 reset underrun", rxUnderrun, 0);

    // first packet, 5 bytes
    startPkt(); bytes(5);
    sbExp(16'h8005, "R7 incomplete status");
    chk("R7 receiving", receiving, 1);
    endPkt(4'h0);
    sbExp(16'h0005, "R2 complete status");
    chk("R9 sole packet closes", rxComplete, 1);
    chk("R7 receiving cleared", receiving, 0);
    for (int i = 0; i < 5; i++) readB();
    chk("R6 no underrun in range", rxUnderrun, 0);
    readB();
    chk("R6 underrun set", rxUnderrun, 1);
    chk("R6 adapterFail pulse", adapterFail, 1);
    sbExp(16'h0005, "R6 status kept");
    idle();
    chk("R6 adapterFail one cycle", adapterFail, 0);
    discard();
    sbExp(16'h8000, "R8 discard to empty");
    chk("R6 underrun holds on discard", rxUnderrun, 1);
    rxRst();
    chk("R11 underrun cleared", rxUnderrun, 0);

    // three packets with codes
    startPkt(); bytes(3); endPkt(4'b1101);
    sbExp(16'h6803, "R10 crc class");
    chk("R9 raised", rxComplete, 1);
    startPkt(); bytes(2); endPkt(4'b0111);
    chk("R9 not raised behind head", rxComplete, 0);
    startPkt(); bytes(1); endPkt(4'b0010);
    sbExp(16'h6803, "R8 head unchanged");
    discard();
    sbExp(16'h0002, "R10 unlisted code cleared");
    chk("R9 re-raise after discard", rxComplete, 1);
    discard();
    sbExp(16'h1001, "R10 dribble class");
    chk("R9 re-raise second", rxComplete, 1);
    discard();
    sbExp(16'h8000, "R8 empty after discards");
    chk("R9 no raise when empty", rxComplete, 0);

    // fill the queue
    for (int k = 0; k < DEPTH; k++) begin startPkt(); bytes(1); endPkt(4'b1000); end
    sbExp(16'h4001, "R10 overrun class");
    chk("R4 status overrun set", statusOverrun, 1);
    startPkt();
    chk("R4 start refused", receiving, 0);
    discard();
    chk("R4 status overrun cleared", statusOverrun, 0);
    startPkt();
    chk("R4 start accepted again", receiving, 1);
    endPkt(4'h0);
    rxRst();
    sbExp(16'h8000, "R11 flush empties");
    chk("R11 statusOverrun zero", statusOverrun, 0);

    // FIFO full handling
    startPkt(); bytes(2); endPkt(4'h0);
    @(negedge clk); fifoFull = 1;
    idle();
    chk("R5 overrun set", rxOverrun, 1);
    startPkt();
    chk("R5 start refused", receiving, 0);
    @(negedge clk); fifoFull = 0;
    idle();
    chk("R5 overrun persists", rxOverrun, 1);
    readB();
    chk("R5 overrun cleared by read", rxOverrun, 0);
    discard();

    // oversize
    startPkt(); bytes(25);
    sbExp(16'h8014, "R3 count saturates");
    endPkt(4'h0);
    sbExp(16'h4814, "R3 oversize class");
    discard();
    startPkt(); bytes(2);
    discard();
    sbExp(16'h8002, "R8 discard of open packet ignored");
    chk("R8 still receiving", receiving, 1);
    endPkt(4'b1011);
    sbExp(16'h5802, "R10 runt class");

    @(negedge clk);
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule